// File: doc/BRIEF.md
# If-Then Block Conditional Execution Sequencer

This block keeps the state of a short predicated run of instructions and decides, for each instruction the pipeline issues, whether that instruction takes effect or is squashed to a no-op. An instruction that opens a predicated run delivers an 8-bit state word through a load strobe. Bits 7:5 of that word give the base condition. Bits 4:0 hold a mask. That mask sets how many of the following instructions are predicated, and for each one whether it uses the base condition or its inverse.

Every retire strobe moves the state to the next slot. When the last slot retires, the state returns to zero. The effective condition of the current instruction is bits 7:4 of the state. It is tested against the live N, Z, C and V flags with no register in the path, so the enable is valid in the same cycle the flags are presented. When the state is zero, no block is active and every instruction executes.

Top module: `itseq_top`

## Requirements
- R1: While `rstN` is low, `itState` is 0x00, `inBlock` is 0 and `execEn` is 1.
- R2: A `load` strobe puts `loadValue` into `itState` on the next rising clock edge.
- R3: `load` has priority. A load while a block is active overwrites the state, and a load together with `retire` stores `loadValue` unchanged.
- R4: A `retire` with no `load`, a nonzero state and `itState[2:0]` not 000 keeps bits 7:5 and shifts bits 4:0 left by one, with a 0 entering bit 0.
- R5: A `retire` with no `load`, a nonzero state and `itState[2:0]` equal to 000 clears `itState` to 0x00.
- R6: A `retire` while `itState` is 0x00 leaves it at 0x00.
- R7: `inBlock` is 1 exactly when `itState` is nonzero.
- R8: When `itState` is 0x00, `execEn` is 1 for every value of `flags`.
- R9: When `itState` is nonzero, `execEn` is the truth of the condition `itState[7:4]`, with `flags` = {N,Z,C,V} (bit 3 N, bit 0 V). The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V).
- R10: Condition codes 14 and 15 always give `execEn` = 1.
- R11: With neither `load` nor `retire`, `itState` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start a new predicated block |
| loadValue | input | 8 | State word delivered with `load` |
| retire | input | 1 | The current instruction retires |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| itState | output | 8 | Current block state |
| inBlock | output | 1 | A predicated block is active |
| execEn | output | 1 | The current instruction takes effect |

## Verification
A wrong state word shows up at the `itState` port in the cycle after the faulty load or retire, because the register drives that port directly. A wrong shift or a missed clear changes the number of predicated slots or the then/else pattern. That error also reaches `execEn` at once once the flags make the base condition and its inverse differ. The bench sweeps all sixteen flag combinations for every condition code, so a single mis-decoded condition is exposed within a few cycles of the load that selects it.

// File: rtl/itseq_pkg.sv
package itseq_pkg;
  localparam int STATE_W = 8;
  localparam int BASE_W = 3;
  localparam int MASK_W = STATE_W - BASE_W;
  localparam int COND_W = BASE_W + 1;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic take;
    logic shift;
    logic clear;
  } itStrobes_t;
endpackage

// File: rtl/itseq_ctrl.sv
module itseq_ctrl
  import itseq_pkg::*;
(
  input  logic       load,
  input  logic       retire,
  input  logic       stateZero,
  input  logic       lastSlot,
  output itStrobes_t strobes
);
  logic stepping;

  always_comb begin
    stepping = retire && !load && !stateZero;
    strobes.take = load;
    strobes.shift = stepping && !lastSlot;
    strobes.clear = stepping && lastSlot;
  end
endmodule

// File: rtl/itseq_state.sv
module itseq_state
  import itseq_pkg::*;
#(
  parameter int WIDTH = STATE_W,
  parameter int BASE = BASE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  itStrobes_t       strobes,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] itState,
  output logic             stateZero,
  output logic             lastSlot
);
  localparam int MW = WIDTH - BASE;

  logic [WIDTH-1:0] nextState;

  always_comb begin
    nextState = itState;
    if (strobes.take) nextState = loadValue;
    else if (strobes.clear) nextState = '0;
    else if (strobes.shift) nextState = {itState[WIDTH-1:MW], itState[MW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) itState <= '0;
    else itState <= nextState;
  end

  assign stateZero = (itState == '0);
  assign lastSlot = (itState[MW-3:0] == '0);
endmodule

// File: rtl/itseq_cond.sv
module itseq_cond
  import itseq_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] flags,
  input  logic              idle,
  output logic              execEn
);
  logic fN, fZ, fC, fV, basePass;

  always_comb begin
    {fN, fZ, fC, fV} = flags;
    unique case (cond[3:1])
      3'd0: basePass = fZ;
      3'd1: basePass = fC;
      3'd2: basePass = fN;
      3'd3: basePass = fV;
      3'd4: basePass = fC && !fZ;
      3'd5: basePass = (fN == fV);
      3'd6: basePass = !fZ && (fN == fV);
      default: basePass = 1'b1;
    endcase
    if (idle || cond[3:1] == 3'd7) execEn = 1'b1;
    else execEn = basePass ^ cond[0];
  end
endmodule

// File: rtl/itseq_top.sv
module itseq_top
  import itseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [STATE_W-1:0] loadValue,
  input  logic               retire,
  input  logic [FLAG_W-1:0]  flags,
  output logic [STATE_W-1:0] itState,
  output logic               inBlock,
  output logic               execEn
);
  itStrobes_t strobes;
  logic stateZero, lastSlot;

  itseq_ctrl u_ctrl (
    .load(load), .retire(retire), .stateZero(stateZero),
    .lastSlot(lastSlot), .strobes(strobes)
  );

  itseq_state #(.WIDTH(STATE_W), .BASE(BASE_W)) u_state (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadValue(loadValue),
    .itState(itState), .stateZero(stateZero), .lastSlot(lastSlot)
  );

  itseq_cond u_cond (
    .cond(itState[STATE_W-1:STATE_W-COND_W]), .flags(flags),
    .idle(stateZero), .execEn(execEn)
  );

  assign inBlock = !stateZero;
endmodule

// File: rtl/itseq_checker.sv
module itseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       load,
  input logic [7:0] loadValue,
  input logic       retire,
  input logic [7:0] itState,
  input logic       execEn
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> itState == 8'h00); // R1
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    load |=> itState == $past(loadValue)); // R2
  AST_SLOT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (!load && retire && itState != 8'h00 && itState[2:0] != 3'b000)
    |=> itState == {$past(itState[7:5]), $past(itState[3:0]), 1'b0}); // R4
  AST_BLOCK_END: assert property (@(posedge clk) disable iff (!rstN)
    (!load && retire && itState != 8'h00 && itState[2:0] == 3'b000)
    |=> itState == 8'h00); // R5
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !retire) |=> $stable(itState)); // R11
  AST_IDLE_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    itState == 8'h00 |-> execEn); // R8
endmodule

bind itseq_top itseq_checker u_checker (
  .clk(clk), .rstN(rstN), .load(load), .loadValue(loadValue),
  .retire(retire), .itState(itState), .execEn(execEn)
);

// File: tb/itseq_top_test.sv
module itseq_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic load = 1'b0;
  logic [7:0] loadValue = 8'h00;
  logic retire = 1'b0;
  logic [3:0] flags = 4'h0;
  logic [7:0] itState;
  logic inBlock, execEn;

  int checks = 0;
  int failures = 0;
  int refState = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  itseq_top uut (
    .clk(clk), .rstN(rstN), .load(load), .loadValue(loadValue),
    .retire(retire), .flags(flags), .itState(itState),
    .inBlock(inBlock), .execEn(execEn)
  );

  function automatic bit condTrue(int code, bit n, bit z, bit c, bit v);
    case (code)
      0: return z;
      1: return !z;
      2: return c;
      3: return !c;
      4: return n;
      5: return !n;
      6: return v;
      7: return !v;
      8: return c && !z;
      9: return !c || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) refState <= 0;
    else if (load) refState <= int'(loadValue);
    else if (retire && refState != 0) begin
      if (refState % 8 == 0) refState <= 0;
      else refState <= (refState & 'hE0) | ((refState * 2) & 'h1F);
    end
  end

  always @(negedge clk) begin
    bit expEn;
    if (refState == 0) expEn = 1'b1;
    else expEn = condTrue(refState / 16, flags[3], flags[2], flags[1], flags[0]);
    checks++;
    if (int'(itState) != refState) begin
      failures++;
      $display("FAIL %s itState actual=%02h expected=%02h", phase, itState, refState[7:0]);
    end
    checks++;
    if (inBlock !== (refState != 0)) begin  // R7
      failures++;
      $display("FAIL R7 inBlock actual=%0b expected=%0b", inBlock, refState != 0);
    end
    checks++;
    if (execEn !== expEn) begin
      failures++;
      $display("FAIL %s execEn actual=%0b expected=%0b state=%02h flags=%h",
               phase, execEn, expEn, itState, flags);
    end
  end

  task automatic drive(bit ld, logic [7:0] val, bit ret, logic [3:0] fl);
    @(posedge clk);
    #2;
    load = ld; loadValue = val; retire = ret; flags = fl;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    phase = "R6";
    drive(0, 8'h00, 1, 4'h0);
    drive(0, 8'h00, 1, 4'hF);
    phase = "R2";
    drive(1, 8'h18, 0, 4'h4);
    drive(0, 8'h00, 0, 4'h0);
    phase = "R11";
    drive(0, 8'h00, 0, 4'hB);
    drive(0, 8'h00, 0, 4'h4);
    phase = "R4";
    drive(1, 8'h0D, 0, 4'h4);
    for (int i = 0; i < 4; i++) drive(0, 8'h00, 1, (i % 2) ? 4'h4 : 4'h0);
    phase = "R5";
    drive(0, 8'h00, 1, 4'h0);
    drive(0, 8'h00, 0, 4'h0);
    phase = "R3";
    drive(1, 8'h2F, 0, 4'h2);
    drive(0, 8'h00, 1, 4'h2);
    drive(1, 8'h98, 0, 4'h2);
    drive(1, 8'h44, 1, 4'h0);
    drive(0, 8'h00, 0, 4'h1);
    phase = "R8";
    drive(1, 8'h00, 0, 4'h0);
    for (int f = 0; f < 16; f++) drive(0, 8'h00, 0, 4'(f));
    phase = "R9";
    for (int c = 0; c < 14; c++) begin
      drive(1, {4'(c), 4'b1000}, 0, 4'h0);
      for (int f = 0; f < 16; f++) drive(0, 8'h00, 0, 4'(f));
    end
    phase = "R10";
    for (int c = 14; c < 16; c++) begin
      drive(1, {4'(c), 4'b1000}, 0, 4'h0);
      for (int f = 0; f < 16; f++) drive(0, 8'h00, 0, 4'(f));
    end
    phase = "R4";
    drive(1, 8'h0A, 0, 4'h4);
    for (int i = 0; i < 4; i++) drive(0, 8'h00, 1, 4'h4);
    phase = "R1";
    @(posedge clk);
    #2 rstN = 1'b0;
    drive(1, 8'h55, 1, 4'h0);
    drive(0, 8'h00, 0, 4'h0);
    #2 rstN = 1'b1;
    drive(0, 8'h00, 0, 4'h0);
    @(posedge clk);
    @(negedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule